// File: doc/BRIEF.md
# Memory-Device Boundary-Scan Test Port

This block is the test access port of a synchronous memory device. A sixteen-state controller advances on every rising edge of the test clock, steered by the mode-select input. A three-bit instruction register chooses which data register sits between the serial input and the serial output: a one-bit bypass stage, a 32-bit identification register, or a boundary register whose length is a parameter. The boundary register samples a parallel I/O-ring vector in Capture-DR. The identification register loads a constant presented on an input port.

Two of the boundary instructions also raise a control output. That output forces the memory's data drivers into high impedance. The instruction that only samples the ring leaves the memory alone and never updates or preloads the boundary cells. Unassigned instruction codes act as bypass.

The serial output and its enable change on the falling edge of the test clock. The enable is high only while shifting. Reset is synchronous and active high.

Top module: `memtap_port`

## Requirements
- R1: While `rst` is high, and on the first edges after it falls, the controller sits in Test-Logic-Reset with the identify code 3'b001 active, `mem_hiz` low and `tdo_en` low.
- R2: Five rising edges with `tms` high bring the controller to Test-Logic-Reset from any state. This reloads the identify code, so that `mem_hiz` is low and a data scan returns the ID.
- R3: Capture-IR loads 3'b001 into the instruction shift stage, which shifts out least significant bit first. A new code takes effect only at Update-IR, so `mem_hiz` keeps its old value through Shift-IR and Exit1-IR.
- R4: Code 3'b001 selects the ID register. Capture-DR loads `id_code`, which shifts out least significant bit first.
- R5: Code 3'b111 selects a one-bit bypass stage that captures 0. The bit shifted in first appears on `tdo` one edge later.
- R6: Code 3'b000 selects the boundary register, captures `io_ring` and drives `mem_hiz` high.
- R7: Code 3'b010 selects the boundary register, captures `io_ring` and drives `mem_hiz` high.
- R8: Code 3'b100 captures `io_ring` into the boundary register and keeps `mem_hiz` low. Data shifted in is never preloaded, so the next capture returns the live `io_ring`.
- R9: Codes 3'b011, 3'b101 and 3'b110 behave as bypass and keep `mem_hiz` low.
- R10: `tdo_en` is high only in Shift-DR and Shift-IR. `tdo` is 0 whenever `tdo_en` is low. Both change only on the falling edge of `tck`.
- R11: `tms` is sampled on the rising edge of `tck` and steers the standard sixteen-state transition graph. For example, Shift-DR with `tms` high moves to Exit1-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in, sampled on the rising edge |
| io_ring | input | BSR_LEN | Parallel I/O-ring values for boundary capture |
| id_code | input | ID_W | Identification constant |
| tdo | output | 1 | Serial data out, updated on the falling edge |
| tdo_en | output | 1 | Serial-out enable, high only while shifting |
| mem_hiz | output | 1 | Forces memory data drivers to high impedance |

## Verification
The assertions assume that `tms` and `tdi` change only while `tck` is low. They also assume that `rst` is held across at least one rising and one falling edge, so that both clock domains start from known values. The stimulus meets these conditions by driving every input just after a falling edge. Each test-port action is built from complete walks through the controller: random instruction codes drawn from a fixed seed, random I/O-ring and bypass data, and random `tms` walks that always end in a five-edge reset. Expected scan contents come from bench functions keyed only on the instruction code.

// File: rtl/memtap_pkg.sv
package memtap_pkg;
  localparam int IR_W = 3;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SELDR, ST_CAPDR, ST_SHDR, ST_EX1DR, ST_PSDR, ST_EX2DR, ST_UPDR,
    ST_SELIR, ST_CAPIR, ST_SHIR, ST_EX1IR, ST_PSIR, ST_EX2IR, ST_UPIR
  } tap_st_e;

  typedef enum logic [1:0] {SEL_BYP, SEL_ID, SEL_BSR} dr_sel_e;

  localparam logic [IR_W-1:0] OP_EXTEST = 3'b000;
  localparam logic [IR_W-1:0] OP_IDENT  = 3'b001;
  localparam logic [IR_W-1:0] OP_SAMPZ  = 3'b010;
  localparam logic [IR_W-1:0] OP_SAMPLE = 3'b100;
  localparam logic [IR_W-1:0] OP_BYPASS = 3'b111;
endpackage

// File: rtl/memtap_fsm.sv
module memtap_fsm
  import memtap_pkg::*;
(
  input  logic    tck,
  input  logic    rst,
  input  logic    tms,
  output tap_st_e st
);
  tap_st_e nxt;

  always_comb begin
    unique case (st)
      ST_TLR:   nxt = tms ? ST_TLR   : ST_RTI;
      ST_RTI:   nxt = tms ? ST_SELDR : ST_RTI;
      ST_SELDR: nxt = tms ? ST_SELIR : ST_CAPDR;
      ST_CAPDR: nxt = tms ? ST_EX1DR : ST_SHDR;
      ST_SHDR:  nxt = tms ? ST_EX1DR : ST_SHDR;
      ST_EX1DR: nxt = tms ? ST_UPDR  : ST_PSDR;
      ST_PSDR:  nxt = tms ? ST_EX2DR : ST_PSDR;
      ST_EX2DR: nxt = tms ? ST_UPDR  : ST_SHDR;
      ST_UPDR:  nxt = tms ? ST_SELDR : ST_RTI;
      ST_SELIR: nxt = tms ? ST_TLR   : ST_CAPIR;
      ST_CAPIR: nxt = tms ? ST_EX1IR : ST_SHIR;
      ST_SHIR:  nxt = tms ? ST_EX1IR : ST_SHIR;
      ST_EX1IR: nxt = tms ? ST_UPIR  : ST_PSIR;
      ST_PSIR:  nxt = tms ? ST_EX2IR : ST_PSIR;
      ST_EX2IR: nxt = tms ? ST_UPIR  : ST_SHIR;
      ST_UPIR:  nxt = tms ? ST_SELDR : ST_RTI;
      default:  nxt = ST_TLR;
    endcase
  end

  always_ff @(posedge tck) begin
    if (rst) st <= ST_TLR;
    else     st <= nxt;
  end
endmodule

// File: rtl/memtap_ir.sv
module memtap_ir
  import memtap_pkg::*;
(
  input  logic            tck,
  input  logic            rst,
  input  tap_st_e         st,
  input  logic            tdi,
  output logic [IR_W-1:0] ir_q,
  output logic            ir_lsb
);
  localparam logic [IR_W-1:0] CAP_PAT = IR_W'(1);

  logic [IR_W-1:0] ir_sh;

  always_ff @(posedge tck) begin
    if (rst) begin
      ir_sh <= CAP_PAT;
      ir_q  <= OP_IDENT;
    end else begin
      unique case (st)
        ST_TLR:   ir_q  <= OP_IDENT;
        ST_CAPIR: ir_sh <= CAP_PAT;
        ST_SHIR:  ir_sh <= {tdi, ir_sh[IR_W-1:1]};
        ST_UPIR:  ir_q  <= ir_sh;
        default:  ;
      endcase
    end
  end

  assign ir_lsb = ir_sh[0];
endmodule

// File: rtl/memtap_dr.sv
module memtap_dr
  import memtap_pkg::*;
#(
  parameter int BSR_LEN = 16,
  parameter int ID_W    = 32
) (
  input  logic               tck,
  input  logic               rst,
  input  tap_st_e            st,
  input  logic               tdi,
  input  dr_sel_e            sel,
  input  logic [BSR_LEN-1:0] io_ring,
  input  logic [ID_W-1:0]    id_code,
  output logic               dr_lsb
);
  logic               byp_q;
  logic [ID_W-1:0]    id_sh;
  logic [BSR_LEN-1:0] bsr_sh;

  always_ff @(posedge tck) begin
    if (rst) begin
      byp_q  <= 1'b0;
      id_sh  <= '0;
      bsr_sh <= '0;
    end else if (st == ST_CAPDR) begin
      unique case (sel)
        SEL_ID:  id_sh  <= id_code;
        SEL_BSR: bsr_sh <= io_ring;
        default: byp_q  <= 1'b0;
      endcase
    end else if (st == ST_SHDR) begin
      unique case (sel)
        SEL_ID:  id_sh  <= {tdi, id_sh[ID_W-1:1]};
        SEL_BSR: bsr_sh <= {tdi, bsr_sh[BSR_LEN-1:1]};
        default: byp_q  <= tdi;
      endcase
    end
  end

  always_comb begin
    unique case (sel)
      SEL_ID:  dr_lsb = id_sh[0];
      SEL_BSR: dr_lsb = bsr_sh[0];
      default: dr_lsb = byp_q;
    endcase
  end
endmodule

// File: rtl/memtap_port.sv
module memtap_port
  import memtap_pkg::*;
#(
  parameter int BSR_LEN = 16,
  parameter int ID_W    = 32
) (
  input  logic               tck,
  input  logic               rst,
  input  logic               tms,
  input  logic               tdi,
  input  logic [BSR_LEN-1:0] io_ring,
  input  logic [ID_W-1:0]    id_code,
  output logic               tdo,
  output logic               tdo_en,
  output logic               mem_hiz
);
  tap_st_e         tap_st;
  logic [IR_W-1:0] ir_q;
  logic            ir_lsb;
  logic            dr_lsb;
  dr_sel_e         sel;

  memtap_fsm u_fsm (.tck(tck), .rst(rst), .tms(tms), .st(tap_st));

  memtap_ir u_ir (
    .tck(tck), .rst(rst), .st(tap_st), .tdi(tdi),
    .ir_q(ir_q), .ir_lsb(ir_lsb)
  );

  always_comb begin
    unique case (ir_q)
      OP_EXTEST, OP_SAMPZ, OP_SAMPLE: sel = SEL_BSR;
      OP_IDENT:                       sel = SEL_ID;
      default:                        sel = SEL_BYP;
    endcase
    mem_hiz = (ir_q == OP_EXTEST) || (ir_q == OP_SAMPZ);
  end

  memtap_dr #(.BSR_LEN(BSR_LEN), .ID_W(ID_W)) u_dr (
    .tck(tck), .rst(rst), .st(tap_st), .tdi(tdi), .sel(sel),
    .io_ring(io_ring), .id_code(id_code), .dr_lsb(dr_lsb)
  );

  always_ff @(negedge tck) begin
    if (rst) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo_en <= (tap_st == ST_SHDR) || (tap_st == ST_SHIR);
      unique case (tap_st)
        ST_SHDR: tdo <= dr_lsb;
        ST_SHIR: tdo <= ir_lsb;
        default: tdo <= 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/memtap_port_chk.sv
module memtap_port_chk
  import memtap_pkg::*;
(
  input logic            tck,
  input logic            rst,
  input logic            tms,
  input tap_st_e         st,
  input logic [IR_W-1:0] ir,
  input logic            mem_hiz,
  input logic            tdo,
  input logic            tdo_en
);
  p_reset_idcode_r1: assert property (@(posedge tck) disable iff (rst)
    (st == ST_TLR) |=> (ir == OP_IDENT));

  p_tlr_hold_r2: assert property (@(posedge tck) disable iff (rst)
    (st == ST_TLR && tms) |=> (st == ST_TLR));

  p_ir_hold_r3: assert property (@(posedge tck) disable iff (rst)
    (st != ST_UPIR && st != ST_TLR) |=> $stable(ir));

  p_tlr_nohiz_r9: assert property (@(posedge tck) disable iff (rst)
    (st == ST_TLR) |=> !mem_hiz);

  p_en_shift_r10: assert property (@(posedge tck) disable iff (rst)
    tdo_en == (st == ST_SHDR || st == ST_SHIR));

  p_tdo_quiet_r10: assert property (@(posedge tck) disable iff (rst)
    !tdo_en |-> !tdo);

  p_shdr_exit_r11: assert property (@(posedge tck) disable iff (rst)
    (st == ST_SHDR && tms) |=> (st == ST_EX1DR));
endmodule

bind memtap_port memtap_port_chk u_chk (
  .tck(tck), .rst(rst), .tms(tms), .st(tap_st), .ir(ir_q),
  .mem_hiz(mem_hiz), .tdo(tdo), .tdo_en(tdo_en)
);

// File: tb/sim_memtap_port.sv
module sim_memtap_port;
  localparam int BSR_LEN = 16;
  localparam int ID_W    = 32;

  logic               tck = 1'b0;
  logic               rst = 1'b1;
  logic               tms = 1'b1;
  logic               tdi = 1'b0;
  logic [BSR_LEN-1:0] io_ring = '0;
  logic [ID_W-1:0]    id_code = 32'h1A5C_00E3;
  logic               tdo, tdo_en, mem_hiz;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #5 tck = ~tck;

  memtap_port #(.BSR_LEN(BSR_LEN), .ID_W(ID_W)) u0 (
    .tck(tck), .rst(rst), .tms(tms), .tdi(tdi), .io_ring(io_ring),
    .id_code(id_code), .tdo(tdo), .tdo_en(tdo_en), .mem_hiz(mem_hiz)
  );

  function automatic logic exp_hiz(input logic [2:0] op);
    return (op == 3'b000) || (op == 3'b010);
  endfunction

  // 0 = boundary, 1 = ID, 2 = bypass
  function automatic int exp_kind(input logic [2:0] op);
    if (op == 3'b000 || op == 3'b010 || op == 3'b100) return 0;
    if (op == 3'b001) return 1;
    return 2;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input logic t, input logic d);
    tms = t;
    tdi = d;
    @(posedge tck);
    @(negedge tck);
    #1;
  endtask

  task automatic load_ir(input logic [2:0] op, output logic [2:0] capt, output logic pre_hiz);
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 3; i++) begin
      capt[i] = tdo;
      tick(i == 2, op[i]);
    end
    pre_hiz = mem_hiz;
    tick(1, 0);
    tick(0, 0);
  endtask

  task automatic scan_dr(input int n, input logic [63:0] din,
                         output logic [63:0] dout, output logic en_ok);
    dout  = '0;
    en_ok = 1'b1;
    tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo;
      en_ok   = en_ok & tdo_en;
      tick(i == n - 1, din[i]);
    end
    tick(1, 0);
    tick(0, 0);
  endtask

  task automatic check_op(input logic [2:0] op, input logic prev_hiz, input string tag);
    logic [2:0]  capt;
    logic        pre;
    logic [63:0] dout;
    logic        en_ok;
    logic        b;
    load_ir(op, capt, pre);
    chk({tag, " R3 capture"}, 64'(capt), 64'(3'b001));
    chk({tag, " R3 no early effect"}, 64'(pre), 64'(prev_hiz));
    chk({tag, " hiz"}, 64'(mem_hiz), 64'(exp_hiz(op)));
    chk({tag, " R10 idle en"}, 64'({tdo_en, tdo}), 64'(0));
    case (exp_kind(op))
      0: begin
        io_ring = BSR_LEN'($urandom);
        scan_dr(BSR_LEN, 64'(~io_ring), dout, en_ok);
        chk({tag, " bsr"}, dout, 64'(io_ring));
      end
      1: begin
        scan_dr(ID_W, 64'(0), dout, en_ok);
        chk({tag, " R4 id"}, dout, 64'(id_code));
      end
      default: begin
        b = 1'($urandom);
        scan_dr(2, 64'({1'b0, b}), dout, en_ok);
        chk({tag, " R5 bypass"}, dout, 64'({b, 1'b0}));
      end
    endcase
    chk({tag, " R10 shift en"}, 64'(en_ok), 64'(1));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: run did not finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic        hz;
    logic [63:0] dout;
    logic        en_ok;
    logic [2:0]  op;
    logic [BSR_LEN-1:0] keep;
    void'($urandom(32'd4711));

    repeat (3) @(negedge tck);
    #1;
    chk("R1 reset hiz/en", 64'({mem_hiz, tdo_en, tdo}), 64'(0));
    rst = 1'b0;
    tick(1, 0);
    chk("R1 after reset hiz", 64'(mem_hiz), 64'(0));
    tick(0, 0);
    scan_dr(ID_W, 64'(0), dout, en_ok);
    chk("R1 R4 reset id", dout, 64'(id_code));
    chk("R10 R11 en during id", 64'(en_ok), 64'(1));

    // Directed: each defined and reserved code
    check_op(3'b000, 1'b0, "R6 extest");
    check_op(3'b010, 1'b1, "R7 samplez");
    check_op(3'b100, 1'b1, "R8 sample");
    check_op(3'b111, 1'b0, "R5 bypass");
    check_op(3'b011, 1'b0, "R9 rsv011");
    check_op(3'b101, 1'b0, "R9 rsv101");
    check_op(3'b110, 1'b0, "R9 rsv110");

    // R8: shifted data never preloads the boundary cells
    check_op(3'b100, 1'b0, "R8 sample2");
    keep = BSR_LEN'($urandom);
    io_ring = keep;
    scan_dr(BSR_LEN, 64'(~keep), dout, en_ok);
    scan_dr(BSR_LEN, 64'(0), dout, en_ok);
    chk("R8 no preload", dout, 64'(keep));

    // R2: reset by tms from EXTEST state after random walk
    check_op(3'b000, 1'b0, "R6 extest2");
    repeat (7) tick(1'($urandom), 1'($urandom));
    repeat (5) tick(1, 0);
    tick(0, 0);
    chk("R2 tms reset hiz", 64'(mem_hiz), 64'(0));
    scan_dr(ID_W, 64'(0), dout, en_ok);
    chk("R2 tms reset id", dout, 64'(id_code));
    hz = 1'b0;

    // Random instruction sequence
    for (int k = 0; k < 40; k++) begin
      op = 3'($urandom);
      id_code = $urandom;
      check_op(op, hz, "R11 random");
      hz = exp_hiz(op);
      if (k % 10 == 9) begin
        repeat (6) tick(1'($urandom), 1'($urandom));
        repeat (5) tick(1, 0);
        tick(0, 0);
        chk("R2 random reset", 64'(mem_hiz), 64'(0));
        hz = 1'b0;
      end
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule